// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block keeps the transmit-pending state for fifteen CAN transmit mailboxes, numbered 1 to 15. It picks one pending mailbox and presents it to a CAN protocol engine. It then reacts to the result the engine reports for that frame.

The CPU reaches the block through a 32-bit register port with five word registers:

| Address | Register | Behaviour |
|---|---|---|
| 0 | pending | Write 1 to request a transmission. |
| 1 | cancel | Write 1 to request an abort. |
| 2 | sent | Write 1 to clear an acknowledge bit. |
| 3 | aborted | Write 1 to clear an acknowledge bit. |
| 4 | control | Bit 0 selects the priority mode (read/write). Bit 1 is the empty-slot flag (write 1 to clear). |

The following state is held outside the block and arrives on input vectors:

- which mailboxes are transmitters,
- which of them have automatic retransmission switched off,
- the identifier of each mailbox.

A mailbox that loses arbitration or meets a bus error stays pending and is offered again. The next choice is always made afresh over the whole pending set. The exception is a mailbox with retransmission disabled: it is dropped and reported as aborted. Every time a pending bit falls, the empty-slot flag is raised. That flag drives the interrupt output.

Top module: `can_tx_sched`

## Requirements
- R1: After reset every register reads 0, `tx_req` is 0 and `irq_empty` is 0.
- R2: A pending bit is set only by writing 1 at address 0, and only if the mailbox's `mb_is_tx` bit is 1. Writing 0 to a pending bit has no effect. Bits 31:16 and bit 0 are never set.
- R3: When `tx_done` is reported for the in-flight mailbox, its pending bit clears and its sent bit (address 2) sets on the same clock edge.
- R4: When `tx_lost` or `tx_error` is reported and retransmission is not disabled, the pending bit stays set and the mailbox competes again.
- R5: When `tx_lost` or `tx_error` is reported for a mailbox whose `mb_no_retx` bit is 1, its pending bit clears, its aborted bit (address 3) sets and `irq_empty` rises.
- R6: Writing 1 at address 1 for a pending mailbox that is not in flight clears its pending bit and sets its aborted bit on that edge.
- R7: A cancel for the in-flight mailbox is held in the cancel register until the frame ends. If `tx_done` arrives, it is a success (sent bit set, aborted bit clear). If `tx_lost` or `tx_error` arrives, it is an abort.
- R8: Any pending bit going from 1 to 0 sets `irq_empty` (address 4 bit 1). Writing 1 to that bit clears it.
- R9: With mode bit 0 (address 4 bit 0) equal to 0, the mailbox chosen is the pending one with the numerically lowest identifier. A tie goes to the lower index. The choice is made again after every result.
- R10: With mode bit 0 equal to 1, the lowest-numbered pending mailbox is chosen.
- R11: While `tx_req` is high, `tx_mailbox` and `tx_id` do not change, and the presented mailbox is pending. `tx_req` falls on the edge that takes a result.
- R12: The sent and aborted bits clear on a write of 1. A hardware set on the same edge wins over the clear.
- R13: Reads of address 0 return 0 in bits 31:16 and bit 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mb_is_tx | input | 16 | Mailbox is configured as a transmitter |
| mb_no_retx | input | 16 | Automatic retransmission disabled per mailbox |
| mb_id | input | 176 | Identifier of each mailbox, 11 bits per slot, slot i at bits [11i+10:11i] |
| tx_req | output | 1 | A frame is offered to the protocol engine |
| tx_mailbox | output | 4 | Index of the offered mailbox |
| tx_id | output | 11 | Identifier of the offered mailbox |
| tx_done | input | 1 | One-cycle pulse: frame sent |
| tx_lost | input | 1 | One-cycle pulse: arbitration lost |
| tx_error | input | 1 | One-cycle pulse: bus error |
| irq_empty | output | 1 | Empty-slot flag |

## Verification
The assertions assume the following about the protocol engine:

- It pulses `tx_done`, `tx_lost` and `tx_error` only while `tx_req` is high.
- It reports at most one result per offered frame.
- The mailbox configuration vectors stay steady while a frame is in flight.

The stimulus keeps within these limits. The engine model in the bench waits for `tx_req` before it pulses a result. Each pulse lasts exactly one clock. The identifier and mode settings change only while the engine is idle, or through register writes whose effect the requirements define.

// File: rtl/can_tx_sched.sv
module can_tx_sched #(
  parameter int NMB = 16,
  parameter int IDW = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NMB-1:0]       mb_is_tx,
  input  logic [NMB-1:0]       mb_no_retx,
  input  logic [NMB*IDW-1:0]   mb_id,
  output logic                 tx_req,
  output logic [$clog2(NMB)-1:0] tx_mailbox,
  output logic [IDW-1:0]       tx_id,
  input  logic                 tx_done,
  input  logic                 tx_lost,
  input  logic                 tx_error,
  output logic                 irq_empty
);
  localparam int IW = $clog2(NMB);
  localparam logic [NMB-1:0] USABLE = {{(NMB-1){1'b1}}, 1'b0};
  localparam logic [2:0] A_PEND = 3'd0, A_CANCEL = 3'd1, A_TXACK = 3'd2,
                         A_ABACK = 3'd3, A_CTRL = 3'd4;

  logic [NMB-1:0] pend, cancel_q, txack, aback;
  logic           mode, irq_q, busy;
  logic [IW-1:0]  cur;

  logic wr_pend, wr_cancel, wr_txack, wr_aback, wr_ctrl;
  assign wr_pend   = reg_we && reg_addr == A_PEND;
  assign wr_cancel = reg_we && reg_addr == A_CANCEL;
  assign wr_txack  = reg_we && reg_addr == A_TXACK;
  assign wr_aback  = reg_we && reg_addr == A_ABACK;
  assign wr_ctrl   = reg_we && reg_addr == A_CTRL;

  logic [NMB-1:0] wmask, inflight, cancel_req, set_m, abort_now, done_m, drop_m, clr, pend_n;
  logic result, ok, fail, drop;

  assign wmask      = reg_wdata[NMB-1:0];
  assign inflight   = busy ? (NMB'(1) << cur) : '0;
  assign result     = busy && (tx_done || tx_lost || tx_error);
  assign ok         = busy && tx_done;
  assign fail       = busy && !tx_done && (tx_lost || tx_error);
  assign cancel_req = wr_cancel ? (wmask & USABLE) : '0;
  assign set_m      = wr_pend ? (wmask & mb_is_tx & USABLE) : '0;
  assign abort_now  = cancel_req & pend & ~inflight;
  assign drop       = fail && (mb_no_retx[cur] || cancel_q[cur] || cancel_req[cur]);
  assign done_m     = ok ? inflight : '0;
  assign drop_m     = drop ? inflight : '0;
  assign clr        = done_m | drop_m | abort_now;
  assign pend_n     = (pend | set_m) & ~clr;

  logic [IW-1:0]  win;
  logic [IDW-1:0] best;
  logic           found;
  always_comb begin
    win   = '0;
    best  = '1;
    found = 1'b0;
    for (int i = NMB - 1; i >= 1; i--) begin
      if (pend_n[i] && (mode || mb_id[i*IDW +: IDW] <= best)) begin
        win   = IW'(i);
        best  = mb_id[i*IDW +: IDW];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      cancel_q <= '0;
      txack    <= '0;
      aback    <= '0;
      mode     <= 1'b0;
      irq_q    <= 1'b0;
      busy     <= 1'b0;
      cur      <= '0;
    end else begin
      pend     <= pend_n;
      cancel_q <= result ? '0 : (cancel_q | (cancel_req & inflight));
      txack    <= (txack & ~(wr_txack ? wmask : '0)) | done_m;
      aback    <= (aback & ~(wr_aback ? wmask : '0)) | drop_m | abort_now;
      if (wr_ctrl) mode <= reg_wdata[0];
      irq_q    <= (irq_q & ~(wr_ctrl && reg_wdata[1])) | (|clr);
      if (busy) begin
        if (result) busy <= 1'b0;
      end else if (found) begin
        busy <= 1'b1;
        cur  <= win;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_PEND:   reg_rdata = 32'(pend);
      A_CANCEL: reg_rdata = 32'(cancel_q);
      A_TXACK:  reg_rdata = 32'(txack);
      A_ABACK:  reg_rdata = 32'(aback);
      A_CTRL:   reg_rdata = {30'd0, irq_q, mode};
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[31:NMB];

  assign tx_req     = busy;
  assign tx_mailbox = cur;
  assign tx_id      = mb_id[cur*IDW +: IDW];
  assign irq_empty  = irq_q;

  assert_pend_rise_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~$past(pend))) |-> $past(wr_pend));
  assert_pend_rise_tx_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & ~$past(pend) & ~$past(mb_is_tx))) == 1'b0);
  assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_done) |=> (txack[$past(tx_mailbox)] && !pend[$past(tx_mailbox)]));
  assert_retry_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done && (tx_lost || tx_error) && !mb_no_retx[tx_mailbox] &&
     !cancel_q[tx_mailbox] && !(wr_cancel && reg_wdata[tx_mailbox]))
    |=> (pend[$past(tx_mailbox)] && !tx_req));
  assert_no_retx_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done && (tx_lost || tx_error) && mb_no_retx[tx_mailbox])
    |=> (!pend[$past(tx_mailbox)] && aback[$past(tx_mailbox)] && irq_empty));
  assert_fall_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> irq_empty);
  assert_stable_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && $past(tx_req)) |-> ($stable(tx_mailbox) && $stable(tx_id)));
  assert_offer_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> pend[tx_mailbox]);
endmodule

// File: tb/can_tx_sched_bench.sv
module can_tx_sched_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [15:0] mb_is_tx = 16'hFFDE, mb_no_retx = '0;
  logic [175:0] mb_id;
  logic tx_req, irq_empty;
  logic [3:0] tx_mailbox;
  logic [10:0] tx_id;
  logic tx_done = 1'b0, tx_lost = 1'b0, tx_error = 1'b0;
  logic [10:0] idv [16];

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  string req_tag = "R1";

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < 16; i++) mb_id[i*11 +: 11] = idv[i];

  can_tx_sched u_can_tx_sched (.*);

  // behavioural reference
  logic [15:0] m_pend, m_cancel, m_txack, m_aback;
  bit m_mode, m_irq, m_busy;
  int m_cur;

  function automatic int pick(logic [15:0] p, bit lowidx);
    int b = -1;
    for (int i = 1; i < 16; i++)
      if (p[i] && (b < 0 || (!lowidx && idv[i] < idv[b]))) b = i;
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_cancel = '0; m_txack = '0; m_aback = '0;
      m_mode = 0; m_irq = 0; m_busy = 0; m_cur = 0;
    end else begin
      logic [15:0] np, creq;
      bit fell, res;
      int s;
      fell = 0;
      res = m_busy && (tx_done || tx_lost || tx_error);
      creq = (reg_we && reg_addr == 1) ? (reg_wdata[15:0] & 16'hFFFE) : '0;
      if (reg_we && reg_addr == 2) m_txack &= ~reg_wdata[15:0];
      if (reg_we && reg_addr == 3) m_aback &= ~reg_wdata[15:0];
      np = m_pend;
      if (reg_we && reg_addr == 0)
        for (int i = 1; i < 16; i++) if (reg_wdata[i] && mb_is_tx[i]) np[i] = 1;
      for (int i = 1; i < 16; i++)
        if (m_pend[i] && creq[i] && !(m_busy && i == m_cur)) begin
          np[i] = 0; m_aback[i] = 1; fell = 1;
        end
      if (m_busy && tx_done) begin
        np[m_cur] = 0; m_txack[m_cur] = 1; fell = 1;
      end else if (m_busy && (tx_lost || tx_error) &&
                   (mb_no_retx[m_cur] || m_cancel[m_cur] || creq[m_cur])) begin
        np[m_cur] = 0; m_aback[m_cur] = 1; fell = 1;
      end
      if (res) m_cancel = '0;
      else if (m_busy && creq[m_cur]) m_cancel[m_cur] = 1;
      if (reg_we && reg_addr == 4 && reg_wdata[1]) m_irq = 0;
      if (fell) m_irq = 1;
      m_pend = np;
      if (m_busy) begin
        if (res) m_busy = 0;
      end else begin
        s = pick(np, m_mode);
        if (s >= 0) begin m_busy = 1; m_cur = s; end
      end
      if (reg_we && reg_addr == 4) m_mode = reg_wdata[0];
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {16'd0, m_pend};
      3'd1: return {16'd0, m_cancel};
      3'd2: return {16'd0, m_txack};
      3'd3: return {16'd0, m_aback};
      3'd4: return {30'd0, m_irq, m_mode};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk({req_tag, " tx_req"}, 32'(tx_req), 32'(m_busy));
    chk({req_tag, " tx_mailbox"}, 32'(tx_mailbox), 32'(m_cur));
    chk({req_tag, " tx_id"}, 32'(tx_id), 32'(idv[m_cur]));
    chk({req_tag, " irq_empty"}, 32'(irq_empty), 32'(m_irq));
    chk({req_tag, " reg_rdata"}, reg_rdata, m_read(reg_addr));
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(bit d, bit l, bit e);
    tx_done = d; tx_lost = l; tx_error = e;
    step(1);
    tx_done = 0; tx_lost = 0; tx_error = 0;
  endtask

  task automatic wait_req();
    for (int k = 0; k < 20 && !tx_req; k++) step(1);
  endtask

  task automatic expect_mb(string tag, int mb);
    wait_req();
    chk(tag, {27'd0, tx_req, tx_mailbox}, {27'd0, 1'b1, 4'(mb)});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) idv[i] = 11'h400 + 11'(i);
    idv[3] = 11'h100; idv[7] = 11'h050; idv[9] = 11'h050;
    idv[12] = 11'h7FF; idv[4] = 11'h010;
    step(3);
    rst_n = 1;
    step(1);
    req_tag = "R1";
    for (int a = 0; a < 5; a++) rd("R1 reset register", 3'(a), 32'd0);
    chk("R1 reset tx_req", 32'(tx_req), 32'd0);

    req_tag = "R2";
    wr(0, 32'hFFFF_0025);
    rd("R2 only tx mailbox set, R13 upper and bit0 zero", 0, 32'h0000_0004);
    wr(0, 32'h0);
    rd("R2 write of zero ignored", 0, 32'h0000_0004);
    expect_mb("R9 single pending offered", 2);
    req_tag = "R3";
    pulse(1, 0, 0);
    rd("R3 pending cleared", 0, 32'h0);
    rd("R3 sent bit set", 2, 32'h4);
    rd("R8 empty flag raised", 4, 32'h2);
    req_tag = "R8";
    wr(4, 32'h2);
    rd("R8 empty flag cleared by write 1", 4, 32'h0);
    req_tag = "R12";
    wr(2, 32'h4);
    rd("R12 sent bit cleared by write 1", 2, 32'h0);

    req_tag = "R9";
    wr(0, 32'h1288);
    expect_mb("R9 lowest id wins, tie to lower index", 7);
    chk("R9 tx_id of chosen", 32'(tx_id), 32'h050);
    pulse(1, 0, 0);
    expect_mb("R9 tie partner next", 9);
    pulse(1, 0, 0);
    expect_mb("R9 next lowest id", 3);
    req_tag = "R4";
    pulse(0, 1, 0);
    rd("R4 lost arbitration keeps pending", 0, 32'h1008);
    expect_mb("R4 retried after loss", 3);
    pulse(1, 0, 0);
    expect_mb("R9 last remaining", 12);
    req_tag = "R11";
    wr(0, 32'h10);
    step(2);
    chk("R11 offer unchanged during frame", 32'(tx_mailbox), 32'd12);
    req_tag = "R4";
    pulse(0, 0, 1);
    rd("R4 bus error keeps pending", 0, 32'h1010);
    req_tag = "R9";
    expect_mb("R9 re-evaluated after error", 4);
    pulse(1, 0, 0);
    expect_mb("R4 errored mailbox retried", 12);
    pulse(1, 0, 0);
    wr(4, 32'h2);
    wr(2, 32'hFFFF);

    req_tag = "R5";
    mb_no_retx = 16'h0040;
    wr(0, 32'h40);
    expect_mb("R5 mailbox offered", 6);
    pulse(0, 0, 1);
    rd("R5 pending dropped", 0, 32'h0);
    rd("R5 aborted bit set", 3, 32'h40);
    chk("R5 empty flag", 32'(irq_empty), 32'd1);
    wr(3, 32'h40);
    wr(4, 32'h2);

    req_tag = "R6";
    wr(0, 32'h0C00);
    expect_mb("R6 lower id offered", 10);
    wr(1, 32'h0800);
    rd("R6 idle mailbox aborted at once", 0, 32'h0400);
    rd("R6 aborted bit set", 3, 32'h0800);
    req_tag = "R7";
    wr(1, 32'h0400);
    rd("R7 in-flight cancel held", 1, 32'h0400);
    rd("R7 in-flight still pending", 0, 32'h0400);
    pulse(1, 0, 0);
    rd("R7 done wins as success", 2, 32'h0400);
    rd("R7 no abort for sent frame", 3, 32'h0800);
    rd("R7 cancel released", 1, 32'h0);
    wr(0, 32'h2000);
    expect_mb("R7 next frame", 13);
    wr(1, 32'h2000);
    pulse(0, 1, 0);
    rd("R7 loss with cancel aborts", 3, 32'h2800);
    rd("R7 pending cleared", 0, 32'h0);

    req_tag = "R10";
    wr(4, 32'h3);
    wr(0, 32'h1088);
    expect_mb("R10 lowest index chosen", 3);
    req_tag = "R12";
    reg_we = 1; reg_addr = 2; reg_wdata = 32'h8; tx_done = 1;
    step(1);
    reg_we = 0; tx_done = 0;
    rd("R12 hardware set beats clear", 2, 32'h0408);
    req_tag = "R10";
    expect_mb("R10 next lowest index", 7);
    pulse(1, 0, 0);
    expect_mb("R10 last", 12);
    pulse(1, 0, 0);

    req_tag = "R13";
    wr(0, 32'hFFFF_0001);
    rd("R13 upper half and bit0 read zero", 0, 32'h0);
    rd("R13 unmapped address", 5, 32'h0);
    rd("R13 unmapped address", 7, 32'h0);
    step(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule